// File: doc/BRIEF.md
# Reciprocal and Inverse Square Root Lookup Unit

This block turns a 32-bit signed fixed-point operand into a 32-bit signed approximation of either its reciprocal or its reciprocal square root. It finds the operand's magnitude and counts the left shifts that bring the leading one into bit 31. It forms a 10-bit address into an external 1024-entry table of 16-bit mantissas, and scales the returned word back down by a shift derived from the same count. Two operand values give fixed results instead of a computed one: zero, and the most negative 16-bit value.

A second input picks how the magnitude is formed. Single mode takes a plain absolute value. Double mode treats a 32-bit operand assembled from a high and a low half. In that mode a negative operand at or above -32768 is negated and one below it is bit-inverted. The table is outside the block and is read synchronously: the address leaves the block in the cycle a request is accepted, and the table word returns one cycle later.

The controller has three states. ST_IDLE waits. ST_LOOKUP is the single cycle in which the table answers. ST_EMIT presents the registered result with `valid_o` high. The transitions are: ST_IDLE to ST_LOOKUP on `start_i`; ST_LOOKUP to ST_EMIT always; ST_EMIT to ST_LOOKUP on `start_i`, otherwise back to ST_IDLE. A start that arrives during ST_LOOKUP is dropped.

Top module: `recip_rsqrt_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `valid_o` is 0 and `result_o` is 0 until the first request completes.
- R2: In the cycle a request is accepted, `tbl_addr_o[9]` equals `root_i`. Let N be the magnitude shifted left by the shift count S. Without root mode the address is {0, N[30:22]}; in root mode it is {1, N[30:23], S[0]}.
- R3: In single mode (`dbl_i`=0) the magnitude is the absolute value of the operand, modulo 2^32.
- R4: In double mode a non-negative operand is used as it is. A negative operand at or above -32768 is negated, and one below -32768 is bit-inverted.
- R5: A zero magnitude uses S=16 in single mode and S=0 in double mode with N=0, so its address is 0x000 without root mode and 0x200 with it.
- R6: For a nonzero magnitude, S is the number of leading zeros. The raw result is (0x40000000 | word<<14) shifted right logically by 31-S; in root mode the shift is (31-S)>>1.
- R7: An operand of 0 yields `result_o` = 0x7FFFFFFF.
- R8: An operand of 0xFFFF8000 (-32768) yields `result_o` = 0xFFFF0000.
- R9: Any other negative operand yields the bitwise inverse of the raw result; a non-negative operand yields the raw result.
- R10: Take E as the clock edge that accepts a request. `valid_o` is high for exactly one cycle, starting at the second edge after E, and `result_o` holds the result then.
- R11: A `start_i` seen in ST_LOOKUP is ignored and produces no extra result.
- R12: A `start_i` seen in ST_EMIT is accepted, so requests can be issued every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| operand_i | input | 32 | Signed operand |
| root_i | input | 1 | 1 selects reciprocal square root |
| dbl_i | input | 1 | 1 selects double-width magnitude rule |
| tbl_addr_o | output | 10 | Table address, valid in the accepting cycle |
| tbl_data_i | input | 16 | Table word, returned one cycle after the address |
| result_o | output | 32 | Signed result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
Several properties are checked on every cycle: the one-cycle shape and two-edge latency of `valid_o`, the dropping of starts during the lookup, the table-half bit of the address, both saturation values, and the sign of every non-saturated result. The exact magnitude cannot be checked that way. It depends on the leading-zero count, the index bits, the root halving of the shift and the table contents. Only the bench scenarios show it, because they compute expected addresses and results from a known table. The same holds for the double-mode negate-or-invert boundary and the zero-magnitude address.

// File: rtl/recip_pkg.sv
package recip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EMIT
    } rr_state_e;

    typedef enum logic [1:0] {
        SAT_NONE,
        SAT_ZERO_IN,
        SAT_MIN_IN
    } sat_kind_e;

endpackage

// File: rtl/recip_norm.sv
// Magnitude, leading-zero normalisation and table address generation.
module recip_norm
    import recip_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 9,
    localparam int ADDR_W = IDX_W + 1,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic              root_i,
    input  logic              dbl_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SH_W-1:0]   rsh_o,
    output sat_kind_e         sat_o,
    output logic              neg_o
);
    localparam logic [DATA_W-1:0] NEG_LIM =
        {{(DATA_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] normed;
    logic [SH_W-1:0]   lz;
    logic [SH_W-1:0]   sh;
    logic              found;
    logic [IDX_W-1:0]  idx;
    logic [SH_W-1:0]   rsh_full;

    // magnitude rule per precision
    always_comb begin
        if (!dbl_i) begin
            mag = operand_i[DATA_W-1] ? (~operand_i + 1'b1) : operand_i;
        end else if (operand_i[DATA_W-1]) begin
            mag = ($signed(operand_i) >= $signed(NEG_LIM)) ? (~operand_i + 1'b1)
                                                           : ~operand_i;
        end else begin
            mag = operand_i;
        end
    end

    // priority leading-zero count
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!found && mag[i]) begin
                lz    = SH_W'(DATA_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (mag == '0) begin
            sh = dbl_i ? '0 : SH_W'(WORD_W);
        end else begin
            sh = lz;
        end
        normed   = mag << sh;
        idx      = normed[DATA_W-2 -: IDX_W];
        rsh_full = SH_W'(DATA_W - 1) - sh;
        if (root_i) begin
            addr_o = {1'b1, idx[IDX_W-1:1], sh[0]};
            rsh_o  = rsh_full >> 1;
        end else begin
            addr_o = {1'b0, idx};
            rsh_o  = rsh_full;
        end
    end

    always_comb begin
        if (operand_i == '0) begin
            sat_o = SAT_ZERO_IN;
        end else if (operand_i == NEG_LIM) begin
            sat_o = SAT_MIN_IN;
        end else begin
            sat_o = SAT_NONE;
        end
        neg_o = operand_i[DATA_W-1];
    end

endmodule

// File: rtl/recip_denorm.sv
// Rescales the table mantissa and applies sign and saturation.
module recip_denorm
    import recip_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 16,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int WORD_POS = DATA_W - 2 - WORD_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SH_W-1:0]   rsh_i,
    input  sat_kind_e         sat_i,
    input  logic              neg_i,
    output logic [DATA_W-1:0] result_o
);
    localparam logic [DATA_W-1:0] LEAD_ONE = DATA_W'(1) << (DATA_W - 2);
    localparam logic [DATA_W-1:0] SAT_POS  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SAT_LOW  =
        {{(DATA_W-WORD_W){1'b1}}, {WORD_W{1'b0}}};

    logic [DATA_W-1:0] scaled;
    logic [DATA_W-1:0] raw;

    always_comb begin
        scaled = {{(DATA_W-WORD_W){1'b0}}, word_i} << WORD_POS;
        raw    = (LEAD_ONE | scaled) >> rsh_i;
        unique case (sat_i)
            SAT_ZERO_IN: result_o = SAT_POS;
            SAT_MIN_IN:  result_o = SAT_LOW;
            default:     result_o = neg_i ? ~raw : raw;
        endcase
    end

endmodule

// File: rtl/recip_ctrl.sv
// Three-state request sequencer: idle, table lookup, emit.
module recip_ctrl
    import recip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic load_o,
    output logic valid_o,
    output logic busy_o
);
    rr_state_e state_q;
    rr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_EMIT;
            ST_EMIT:   state_d = start_i ? ST_LOOKUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o   = (state_q == ST_LOOKUP);
        accept_o = start_i && (state_q != ST_LOOKUP);
        load_o   = (state_q == ST_LOOKUP);
        valid_o  = (state_q == ST_EMIT);
    end

endmodule

// File: rtl/recip_rsqrt_unit.sv
module recip_rsqrt_unit
    import recip_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 9,
    localparam int ADDR_W = IDX_W + 1,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              root_i,
    input  logic              dbl_i,
    output logic [ADDR_W-1:0] tbl_addr_o,
    input  logic [WORD_W-1:0] tbl_data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);
    logic              accept_w;
    logic              load_w;
    logic              busy_w;
    logic [SH_W-1:0]   rsh_w;
    sat_kind_e         sat_w;
    logic              neg_w;
    logic [SH_W-1:0]   rsh_q;
    sat_kind_e         sat_q;
    logic              neg_q;
    logic [DATA_W-1:0] res_w;
    logic [DATA_W-1:0] res_q;

    recip_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept_w),
        .load_o   (load_w),
        .valid_o  (valid_o),
        .busy_o   (busy_w)
    );

    recip_norm #(.DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_norm (
        .operand_i (operand_i),
        .root_i    (root_i),
        .dbl_i     (dbl_i),
        .addr_o    (tbl_addr_o),
        .rsh_o     (rsh_w),
        .sat_o     (sat_w),
        .neg_o     (neg_w)
    );

    // context kept across the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsh_q <= '0;
            sat_q <= SAT_NONE;
            neg_q <= 1'b0;
        end else if (accept_w) begin
            rsh_q <= rsh_w;
            sat_q <= sat_w;
            neg_q <= neg_w;
        end
    end

    recip_denorm #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_denorm (
        .word_i   (tbl_data_i),
        .rsh_i    (rsh_q),
        .sat_i    (sat_q),
        .neg_i    (neg_q),
        .result_o (res_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (load_w) begin
            res_q <= res_w;
        end
    end

    assign result_o = res_q;

endmodule

// File: rtl/recip_rsqrt_chk.sv
module recip_rsqrt_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              root_i,
    input logic [ADDR_W-1:0] tbl_addr_o,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              busy_i
);
    localparam logic [DATA_W-1:0] MIN_IN  =
        {{(DATA_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] SAT_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SAT_LOW =
        {{(DATA_W-WORD_W){1'b1}}, {WORD_W{1'b0}}};

    logic [DATA_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (start_i && !busy_i) begin
            cap_q <= operand_i;
        end
    end

    // R2
    addr_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (tbl_addr_o[ADDR_W-1] == root_i));

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_i) |-> ##2 valid_o);

    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_i) |=> (valid_o ##1 !valid_o));

    // R7
    zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cap_q == '0) |-> (result_o == SAT_POS));

    // R8
    min_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cap_q == MIN_IN) |-> (result_o == SAT_LOW));

    // R9
    sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cap_q != '0 && cap_q != MIN_IN)
            |-> (result_o[DATA_W-1] == cap_q[DATA_W-1]));

endmodule

bind recip_rsqrt_unit recip_rsqrt_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .operand_i  (operand_i),
    .root_i     (root_i),
    .tbl_addr_o (tbl_addr_o),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .busy_i     (busy_w)
);

// File: tb/recip_rsqrt_unit_bench.sv
module recip_rsqrt_unit_bench;

    typedef struct {
        logic [31:0] value;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic        root_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic [9:0]  tbl_addr_o;
    logic [15:0] tbl_data_i;
    logic [31:0] result_o;
    logic        valid_o;

    int   total = 0;
    int   bad = 0;
    int   seen = 0;
    int   issued = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    recip_rsqrt_unit u_recip_rsqrt_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .operand_i  (operand_i),
        .root_i     (root_i),
        .dbl_i      (dbl_i),
        .tbl_addr_o (tbl_addr_o),
        .tbl_data_i (tbl_data_i),
        .result_o   (result_o),
        .valid_o    (valid_o)
    );

    function automatic logic [15:0] tbl_fn(input logic [9:0] a);
        return {a[7:0], ~a[9:2]} ^ 16'h5A3C;
    endfunction

    // behavioural synchronous table
    always @(posedge clk) tbl_data_i <= tbl_fn(tbl_addr_o);

    function automatic logic [31:0] ref_mag(input logic [31:0] op, input bit dbl);
        longint v;
        v = longint'($signed(op));
        if (!dbl) return (v < 0) ? 32'(-v) : op;
        if (v >= 0) return op;
        return (v >= -32768) ? 32'(-v) : ~op;
    endfunction

    function automatic int ref_shift(input logic [31:0] op, input bit dbl);
        logic [31:0] m;
        int s;
        m = ref_mag(op, dbl);
        if (m == 0) return dbl ? 0 : 16;
        s = 0;
        while (!m[31]) begin
            m = m << 1;
            s++;
        end
        return s;
    endfunction

    function automatic logic [9:0] ref_addr(input logic [31:0] op, input bit root, input bit dbl);
        logic [31:0] n;
        int s;
        s = ref_shift(op, dbl);
        n = ref_mag(op, dbl) << s;
        if (root) return {1'b1, n[30:23], s[0]};
        return {1'b0, n[30:22]};
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] op, input bit root, input bit dbl);
        int rs;
        logic [31:0] raw;
        rs = 31 - ref_shift(op, dbl);
        if (root) rs = rs / 2;
        raw = (32'h4000_0000 | ({16'h0, tbl_fn(ref_addr(op, root, dbl))} << 14)) >> rs;
        if (op == 32'h0) return 32'h7FFF_FFFF;
        if (op == 32'hFFFF_8000) return 32'hFFFF_0000;
        return op[31] ? ~raw : raw;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: presents one request and queues its expected result
    task automatic issue(input logic [31:0] op, input bit root, input bit dbl, input string tag);
        exp_t e;
        @(negedge clk);
        operand_i = op;
        root_i    = root;
        dbl_i     = dbl;
        start_i   = 1'b1;
        #1;
        check({tag, " R2 addr"}, {22'h0, tbl_addr_o}, {22'h0, ref_addr(op, root, dbl)});
        e.value = ref_res(op, root, dbl);
        e.tag   = tag;
        sb.push_back(e);
        issued++;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            seen++;
            if (sb.size() == 0) begin
                check("R11 unexpected result", result_o, 32'hDEAD_BEEF ^ result_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, result_o, e.value);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'h0, valid_o}, 32'h0);
        check("R1 result in reset", result_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'h0, valid_o}, 32'h0);

        // R6 plain reciprocal, several normalisations
        issue(32'h0000_0001, 1'b0, 1'b0, "R6 one");
        issue(32'h0000_7FFF, 1'b0, 1'b0, "R6 max16");
        issue(32'h0000_1234, 1'b1, 1'b0, "R6 root even");
        issue(32'h0000_0003, 1'b1, 1'b0, "R6 root odd shift");
        issue(32'h0000_0006, 1'b1, 1'b0, "R6 root even shift");
        // R3 single-mode absolute value, R9 inversion
        issue(32'hFFFF_FFFB, 1'b0, 1'b0, "R3 R9 neg five");
        issue(32'hFFFF_FFFB, 1'b1, 1'b0, "R3 R9 neg five root");
        issue(32'h8000_0000, 1'b0, 1'b0, "R3 most negative 32");
        // R7 / R5 zero
        issue(32'h0000_0000, 1'b0, 1'b0, "R7 R5 zero single");
        issue(32'h0000_0000, 1'b1, 1'b1, "R7 R5 zero double root");
        issue(32'h0000_0000, 1'b1, 1'b0, "R7 R5 zero single root");
        // R8
        issue(32'hFFFF_8000, 1'b0, 1'b0, "R8 min16");
        issue(32'hFFFF_8000, 1'b1, 1'b1, "R8 min16 double root");
        // R4 double mode
        issue(32'h1234_5678, 1'b0, 1'b1, "R4 double positive");
        issue(32'hFFFF_FF9C, 1'b0, 1'b1, "R4 double negate");
        issue(32'hFFFF_7FFF, 1'b0, 1'b1, "R4 double invert");
        issue(32'h8000_0001, 1'b1, 1'b1, "R4 double invert root");

        // R12: the issues above ran back to back; now with a gap
        repeat (4) @(negedge clk);
        issue(32'h0001_0000, 1'b0, 1'b0, "R12 after idle");

        // R11: a second start held into the lookup cycle is dropped
        repeat (3) @(negedge clk);
        operand_i = 32'h0000_0100;
        root_i    = 1'b0;
        dbl_i     = 1'b0;
        start_i   = 1'b1;
        begin
            exp_t e;
            e.value = ref_res(32'h0000_0100, 1'b0, 1'b0);
            e.tag   = "R11 first kept";
            sb.push_back(e);
            issued++;
        end
        @(negedge clk);
        operand_i = 32'h0000_0200;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);

        check("R11 results vs requests", 32'(seen), 32'(issued));
        check("R10 queue drained", 32'(sb.size()), 32'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule